// File: doc/BRIEF.md
# Multiway Branch Priority Resolver

This block picks the next program counter for a wide instruction word that can carry several conditional branch operations at once. It holds a small bank of one-bit condition registers. Compare-equal operations write these registers, and the branch slots test them. Because every compare result goes to an addressable register rather than a single implicit flag, any later branch can test any stored result.

Each branch slot has a valid bit, a condition-register select and a target address. A slot is taken when it is valid and the register it selects holds 1. When several slots are taken in the same cycle, the slot with the lowest index wins, and its target becomes the next PC. When no slot is taken, the next PC is the current PC advanced by one instruction word. The block also outputs a taken flag and the index of the winning slot.

The branch outputs are combinational from the current inputs and the stored condition bits. Compare writes take effect at the clock edge.

Top module: `mbr_resolver`

## Requirements
- R1: A valid compare operation writes 1 to its destination condition register when its two operands are equal, and 0 otherwise. The new value is visible from the next cycle on.
- R2: A condition register keeps its value until a compare operation writes it. Any slot can test any register, including the last one (index CONDS-1).
- R3: A slot counts as taken only when its valid bit is 1 and the register it selects holds 1. An invalid slot has no effect on the outputs, even when its selected register holds 1.
- R4: When one or more slots are taken, br_taken is 1, br_slot is the lowest taken slot index, and next_pc equals that slot's target. Slot i's target is slot_target[i*AW +: AW], and its select is slot_sel[i*CW +: CW].
- R5: When no slot is taken, br_taken is 0, br_slot is 0, and next_pc is pc + PC_STEP, wrapping modulo 2^AW.
- R6: A branch that reads a condition register in the same cycle as a compare writes that register sees the old value.
- R7: When two compare ports write the same register in one cycle, the lower-numbered port's result is stored. Port p uses cmp_dest[p*CW +: CW], cmp_a[p*DW +: DW] and cmp_b[p*DW +: DW].
- R8: A synchronous active-high reset clears every condition register to 0. Compare operations presented while reset is high are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | CMPS | One enable per compare port |
| cmp_dest | input | CMPS*CW | Destination condition register of each compare port |
| cmp_a | input | CMPS*DW | First operand of each compare port |
| cmp_b | input | CMPS*DW | Second operand of each compare port |
| pc | input | AW | Address of the current instruction word |
| slot_valid | input | SLOTS | Valid bit of each branch slot |
| slot_sel | input | SLOTS*CW | Condition register tested by each slot |
| slot_target | input | SLOTS*AW | Target address of each slot |
| next_pc | output | AW | Resolved next program counter |
| br_taken | output | 1 | A slot was taken |
| br_slot | output | SW | Index of the winning slot (0 when none is taken) |

## Verification
The bench uses the default parameters: four slots, sixteen condition registers, two compare ports, 32-bit addresses and operands, and a step of one. With these values the bench can reach the outermost slot, the highest register index, two compare ports colliding on one register, and a PC of all ones whose fall-through wraps to zero. The stimulus table interleaves compare writes with branch reads of the same registers, so each row checks both the priority and the old-value read rule against a register history that the bench tracks by hand.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    // Default geometry of the resolver
    localparam int DEF_SLOTS   = 4;
    localparam int DEF_CONDS   = 16;
    localparam int DEF_CMPS    = 2;
    localparam int DEF_AW      = 32;
    localparam int DEF_DW      = 32;
    localparam int DEF_PC_STEP = 1;

    // Outcome of arbitration among branch slots
    typedef enum logic {
        RES_FALLTHROUGH = 1'b0,
        RES_BRANCH      = 1'b1
    } res_kind_e;

    // Width of an index into n items, never below one bit
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mbr_cmp_unit.sv
module mbr_cmp_unit #(
    parameter int DW = mbr_pkg::DEF_DW
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          equal
);
    assign equal = (op_a == op_b);
endmodule

// File: rtl/mbr_cond_bank.sv
module mbr_cond_bank #(
    parameter int CONDS = mbr_pkg::DEF_CONDS,
    parameter int CMPS  = mbr_pkg::DEF_CMPS,
    parameter int DW    = mbr_pkg::DEF_DW,
    localparam int CW   = mbr_pkg::idx_width(CONDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CMPS-1:0]     cmp_valid,
    input  logic [CMPS*CW-1:0]  cmp_dest,
    input  logic [CMPS*DW-1:0]  cmp_a,
    input  logic [CMPS*DW-1:0]  cmp_b,
    output logic [CONDS-1:0]    cond_q
);
    logic [CMPS-1:0]  port_eq;
    logic [CONDS-1:0] cond_d;

    // One comparator per compare port
    for (genvar p = 0; p < CMPS; p++) begin : g_cmp
        mbr_cmp_unit #(.DW(DW)) u_cmp (
            .op_a  (cmp_a[p*DW +: DW]),
            .op_b  (cmp_b[p*DW +: DW]),
            .equal (port_eq[p])
        );
    end

    // Walk ports from highest to lowest so the lowest port's write wins
    always_comb begin
        cond_d = cond_q;
        for (int p = CMPS - 1; p >= 0; p--) begin
            if (cmp_valid[p]) begin
                cond_d[cmp_dest[p*CW +: CW]] = port_eq[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
        end else begin
            cond_q <= cond_d;
        end
    end
endmodule

// File: rtl/mbr_slot_eval.sv
module mbr_slot_eval #(
    parameter int SLOTS = mbr_pkg::DEF_SLOTS,
    parameter int CONDS = mbr_pkg::DEF_CONDS,
    localparam int CW   = mbr_pkg::idx_width(CONDS)
) (
    input  logic [CONDS-1:0]    cond_q,
    input  logic [SLOTS-1:0]    slot_valid,
    input  logic [SLOTS*CW-1:0] slot_sel,
    output logic [SLOTS-1:0]    slot_hit
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign slot_hit[i] = slot_valid[i] & cond_q[slot_sel[i*CW +: CW]];
    end
endmodule

// File: rtl/mbr_prio_pick.sv
module mbr_prio_pick #(
    parameter int SLOTS = mbr_pkg::DEF_SLOTS,
    localparam int SW   = mbr_pkg::idx_width(SLOTS)
) (
    input  logic [SLOTS-1:0]   slot_hit,
    output mbr_pkg::res_kind_e kind,
    output logic [SW-1:0]      win
);
    // The lowest index is visited last, so it overrides every later slot
    always_comb begin
        kind = mbr_pkg::RES_FALLTHROUGH;
        win  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                kind = mbr_pkg::RES_BRANCH;
                win  = SW'(i);
            end
        end
    end
endmodule

// File: rtl/mbr_resolver.sv
module mbr_resolver #(
    parameter int SLOTS   = mbr_pkg::DEF_SLOTS,
    parameter int CONDS   = mbr_pkg::DEF_CONDS,
    parameter int CMPS    = mbr_pkg::DEF_CMPS,
    parameter int AW      = mbr_pkg::DEF_AW,
    parameter int DW      = mbr_pkg::DEF_DW,
    parameter int PC_STEP = mbr_pkg::DEF_PC_STEP,
    localparam int CW     = mbr_pkg::idx_width(CONDS),
    localparam int SW     = mbr_pkg::idx_width(SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CMPS-1:0]     cmp_valid,
    input  logic [CMPS*CW-1:0]  cmp_dest,
    input  logic [CMPS*DW-1:0]  cmp_a,
    input  logic [CMPS*DW-1:0]  cmp_b,
    input  logic [AW-1:0]       pc,
    input  logic [SLOTS-1:0]    slot_valid,
    input  logic [SLOTS*CW-1:0] slot_sel,
    input  logic [SLOTS*AW-1:0] slot_target,
    output logic [AW-1:0]       next_pc,
    output logic                br_taken,
    output logic [SW-1:0]       br_slot
);
    logic [CONDS-1:0]   cond_q;
    logic [SLOTS-1:0]   slot_hit;
    mbr_pkg::res_kind_e kind;
    logic [SW-1:0]      win;
    logic [AW-1:0]      seq_pc;

    mbr_cond_bank #(.CONDS(CONDS), .CMPS(CMPS), .DW(DW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .cmp_dest  (cmp_dest),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .cond_q    (cond_q)
    );

    mbr_slot_eval #(.SLOTS(SLOTS), .CONDS(CONDS)) u_eval (
        .cond_q     (cond_q),
        .slot_valid (slot_valid),
        .slot_sel   (slot_sel),
        .slot_hit   (slot_hit)
    );

    mbr_prio_pick #(.SLOTS(SLOTS)) u_pick (
        .slot_hit (slot_hit),
        .kind     (kind),
        .win      (win)
    );

    assign seq_pc   = pc + AW'(PC_STEP);
    assign br_taken = (kind == mbr_pkg::RES_BRANCH);
    assign br_slot  = win;
    assign next_pc  = br_taken ? slot_target[win*AW +: AW] : seq_pc;
endmodule

// File: rtl/mbr_resolver_chk.sv
module mbr_resolver_chk #(
    parameter int SLOTS   = mbr_pkg::DEF_SLOTS,
    parameter int CONDS   = mbr_pkg::DEF_CONDS,
    parameter int CMPS    = mbr_pkg::DEF_CMPS,
    parameter int AW      = mbr_pkg::DEF_AW,
    parameter int DW      = mbr_pkg::DEF_DW,
    parameter int PC_STEP = mbr_pkg::DEF_PC_STEP,
    localparam int CW     = mbr_pkg::idx_width(CONDS),
    localparam int SW     = mbr_pkg::idx_width(SLOTS)
) (
    input logic                clk,
    input logic                rst,
    input logic [CMPS-1:0]     cmp_valid,
    input logic [CMPS*CW-1:0]  cmp_dest,
    input logic [CMPS*DW-1:0]  cmp_a,
    input logic [CMPS*DW-1:0]  cmp_b,
    input logic [AW-1:0]       pc,
    input logic [SLOTS-1:0]    slot_valid,
    input logic [SLOTS*CW-1:0] slot_sel,
    input logic [SLOTS*AW-1:0] slot_target,
    input logic [AW-1:0]       next_pc,
    input logic                br_taken,
    input logic [SW-1:0]       br_slot,
    input logic [CONDS-1:0]    cond_q
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R8: the first cycle after reset sees an empty register bank
    always @(posedge clk) begin
        if (rst_d && !rst) begin
            p_reset_clear_r8: assert (cond_q == '0)
                else $error("condition bank not cleared after reset");
        end
    end

    // R1 and R7: port 0 always lands in its destination register
    p_cmp_write_r1: assert property (@(posedge clk) disable iff (rst)
        cmp_valid[0] |=> cond_q[$past(cmp_dest[CW-1:0])] ==
                         ($past(cmp_a[DW-1:0]) == $past(cmp_b[DW-1:0])));

    // R2: with no compare activity the bank holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid == '0) |=> $stable(cond_q));

    // R3: a taken result needs a valid slot whose condition is set
    p_taken_cond_r3: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (slot_valid[br_slot] && cond_q[slot_sel[br_slot*CW +: CW]]));

    // R4: the chosen target is delivered
    p_target_r4: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (next_pc == slot_target[br_slot*AW +: AW]));

    // R4: a taken slot is never passed over for a later one
    for (genvar i = 0; i < SLOTS; i++) begin : g_prio
        p_no_skip_r4: assert property (@(posedge clk) disable iff (rst)
            (slot_valid[i] && cond_q[slot_sel[i*CW +: CW]]) |->
                (br_taken && (int'(br_slot) <= i)));
    end

    // R5: fall-through advances by one word
    p_fallthrough_r5: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> ((next_pc == pc + AW'(PC_STEP)) && (br_slot == '0)));
endmodule

bind mbr_resolver mbr_resolver_chk #(
    .SLOTS(SLOTS), .CONDS(CONDS), .CMPS(CMPS),
    .AW(AW), .DW(DW), .PC_STEP(PC_STEP)
) u_chk (.*);

// File: tb/mbr_resolver_tb.sv
module mbr_resolver_tb;
    localparam int SLOTS = 4;
    localparam int CONDS = 16;
    localparam int CMPS  = 2;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int CW    = 4;
    localparam int SW    = 2;

    typedef struct packed {
        logic        c0v;
        logic [3:0]  c0d;
        logic [7:0]  c0a;
        logic [7:0]  c0b;
        logic        c1v;
        logic [3:0]  c1d;
        logic [7:0]  c1a;
        logic [7:0]  c1b;
        logic [3:0]  vm;
        logic [15:0] sels;
        logic [31:0] pcv;
        logic        et;
        logic [1:0]  es;
        logic [31:0] epc;
    } vec_t;

    // Slot i target is 32'hA000_0000 + i*32'h100; sels packs {s3,s2,s1,s0}
    localparam vec_t VEC [9] = '{
        // R6 R1 R5: cond3 written this cycle, still read as 0
        '{1'b1,4'd3,8'd5,8'd5, 1'b1,4'd7,8'd1,8'd2, 4'b1111,16'h3333,32'h100, 1'b0,2'd0,32'h101},
        // R4: slot1 is first with a set condition
        '{1'b0,4'd0,8'd0,8'd0, 1'b0,4'd0,8'd0,8'd0, 4'b1111,16'h3330,32'h200, 1'b1,2'd1,32'hA000_0100},
        // R6 R4: cond9 written now reads 0, slot2 wins
        '{1'b1,4'd9,8'd4,8'd4, 1'b1,4'd12,8'd7,8'd7, 4'b0101,16'h3339,32'h210, 1'b1,2'd2,32'hA000_0200},
        // R3: invalid slots 0 and 1 see cond9=1 but are ignored
        '{1'b0,4'd0,8'd0,8'd0, 1'b0,4'd0,8'd0,8'd0, 4'b1100,16'hC799,32'h220, 1'b1,2'd3,32'hA000_0300},
        // R7 setup: both ports write cond3; R4 slot0 wins
        '{1'b1,4'd3,8'd1,8'd2, 1'b1,4'd3,8'd6,8'd6, 4'b1111,16'h9999,32'h230, 1'b1,2'd0,32'hA000_0000},
        // R7: port0 (unequal) won, cond3 is 0
        '{1'b0,4'd0,8'd0,8'd0, 1'b0,4'd0,8'd0,8'd0, 4'b0010,16'h003C,32'h300, 1'b0,2'd0,32'h301},
        // R6: port1 clears cond9, old 1 still seen
        '{1'b0,4'd0,8'd0,8'd0, 1'b1,4'd9,8'd2,8'd3, 4'b1111,16'h00C9,32'h310, 1'b1,2'd0,32'hA000_0000},
        // R1 R2: cond9 now 0, cond12 still 1
        '{1'b0,4'd0,8'd0,8'd0, 1'b0,4'd0,8'd0,8'd0, 4'b1111,16'h00C9,32'h320, 1'b1,2'd1,32'hA000_0100},
        // R5: no valid slot, PC wraps
        '{1'b0,4'd0,8'd0,8'd0, 1'b0,4'd0,8'd0,8'd0, 4'b0000,16'hCCCC,32'hFFFF_FFFF, 1'b0,2'd0,32'h0}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [CMPS-1:0]     cmp_valid = '0;
    logic [CMPS*CW-1:0]  cmp_dest  = '0;
    logic [CMPS*DW-1:0]  cmp_a     = '0;
    logic [CMPS*DW-1:0]  cmp_b     = '0;
    logic [AW-1:0]       pc        = '0;
    logic [SLOTS-1:0]    slot_valid = '0;
    logic [SLOTS*CW-1:0] slot_sel   = '0;
    logic [SLOTS*AW-1:0] slot_target;
    logic [AW-1:0]       next_pc;
    logic                br_taken;
    logic [SW-1:0]       br_slot;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    for (genvar i = 0; i < SLOTS; i++) begin : g_tgt
        assign slot_target[i*AW +: AW] = 32'hA000_0000 + 32'(i) * 32'h100;
    end

    mbr_resolver u_dut (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_dest(cmp_dest),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .pc(pc), .slot_valid(slot_valid),
        .slot_sel(slot_sel), .slot_target(slot_target), .next_pc(next_pc),
        .br_taken(br_taken), .br_slot(br_slot)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input string req, input logic et,
                             input logic [1:0] es, input logic [31:0] epc);
        check(req, "br_taken", 32'(br_taken), 32'(et));
        check(req, "br_slot",  32'(br_slot),  32'(es));
        check(req, "next_pc",  next_pc,       epc);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state, all slots valid but all conditions clear
        slot_valid = 4'b1111;
        slot_sel   = 16'h3210;
        pc         = 32'h40;
        #2;
        check_out("R8", 1'b0, 2'd0, 32'h41);

        foreach (VEC[k]) begin
            @(negedge clk);
            cmp_valid  = {VEC[k].c1v, VEC[k].c0v};
            cmp_dest   = {VEC[k].c1d, VEC[k].c0d};
            cmp_a      = {24'd0, VEC[k].c1a, 24'd0, VEC[k].c0a};
            cmp_b      = {24'd0, VEC[k].c1b, 24'd0, VEC[k].c0b};
            slot_valid = VEC[k].vm;
            slot_sel   = VEC[k].sels;
            pc         = VEC[k].pcv;
            #2;
            check_out($sformatf("R4/R5 row %0d", k), VEC[k].et, VEC[k].es, VEC[k].epc);
        end

        // R2: highest register index written with full-width equal operands
        @(negedge clk);
        cmp_valid  = 2'b01;
        cmp_dest   = {4'd0, 4'd15};
        cmp_a      = {32'd0, 32'hFFFF_FFFF};
        cmp_b      = {32'd1, 32'hFFFF_FFFF};
        slot_valid = 4'b0000;
        @(negedge clk);
        cmp_valid  = 2'b00;
        slot_valid = 4'b1000;
        slot_sel   = 16'hF000;
        pc         = 32'h500;
        #2;
        check_out("R2", 1'b1, 2'd3, 32'hA000_0300);

        // R1: a one-bit operand difference in the top bit gives 0
        @(negedge clk);
        cmp_valid = 2'b01;
        cmp_dest  = {4'd0, 4'd15};
        cmp_a     = {32'd0, 32'h8000_0000};
        cmp_b     = {32'd0, 32'h0000_0000};
        @(negedge clk);
        cmp_valid = 2'b00;
        #2;
        check_out("R1", 1'b0, 2'd0, 32'h501);

        // R8: reset clears stored bits (cond12 was 1) and drops a write to cond5
        @(negedge clk);
        rst       = 1'b1;
        cmp_valid = 2'b01;
        cmp_dest  = {4'd0, 4'd5};
        cmp_a     = '0;
        cmp_b     = '0;
        @(negedge clk);
        @(negedge clk);
        rst        = 1'b0;
        cmp_valid  = 2'b00;
        slot_valid = 4'b1111;
        slot_sel   = {4'd5, 4'd9, 4'd15, 4'd12};
        pc         = 32'h600;
        #2;
        check_out("R8", 1'b0, 2'd0, 32'h601);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule